// File: doc/BRIEF.md
# Tuning Voltage Pulse Generator

This block turns a 14-bit control word into a single-bit pulse stream. After an external low-pass filter, the average level of that stream is the reference voltage for a tuner. The word has two parts. The upper 8 bits are the coarse part: they set the high time of a pulse-width modulated period that is always 256 clocks long. The lower 6 bits are the fine part: they add one extra high clock to some of the 64 periods that make up a repeating frame. The periods that get the extra clock are chosen by the bit-reversed period index, which spreads them evenly across the frame.

Software writes a new word through a one-cycle write strobe. The word is applied only at the next frame boundary, so a frame is never built from two different words. One select bit chooses which of two output pins carries the stream. The other pin stays low. Clearing the enable drives both pins low and rewinds the frame.

Top module: `vsyn_top`

## Requirements
- R1: After reset, both output pins are low, the frame counters are at their start and the applied word is zero.
- R2: While enabled, every period is 256 clocks long. In period p, the output is high for clocks 0 to H-1 of the period and low for the rest. H is the coarse field (bits 13:6) plus one when that period is extended.
- R3: A frame is 64 periods. Period p (0 to 63) is extended when its index with the 6 bits reversed is less than the fine field (bits 5:0). A frame therefore holds 64*coarse + fine high clocks. For example, fine = 1 extends only period 0, and fine = 32 extends exactly the even periods.
- R4: An applied word of zero keeps both pins low on every cycle.
- R5: The word 16383 keeps the output high through all of periods 0 to 62. Period 63 is high for 255 clocks and low on its last clock.
- R6: A word written while the block is enabled has no effect until the current frame ends. The new word controls the output from the first clock of the next frame.
- R7: With select at 0, the stream appears on `vsOut0` and `vsOut1` is low. With select at 1, the stream appears on `vsOut1` and `vsOut0` is low. The two pins are never high together.
- R8: One clock after the enable is sampled low, both pins are low. While disabled, the counters stay at the frame start and the last written word is applied at once. After the enable rises, the output shows clock 0 of period 0 one clock after the first edge that samples it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Strobe that captures `wrData` as the pending word |
| wrData | input | 14 | Control word: coarse field in bits 13:6, fine field in bits 5:0 |
| enable | input | 1 | Runs the generator; when low, both pins are low |
| outSel | input | 1 | Selects the output pin: 0 for `vsOut0`, 1 for `vsOut1` |
| vsOut0 | output | 1 | Pulse output pin 0 |
| vsOut1 | output | 1 | Pulse output pin 1 |

## Verification
The assertions check on every cycle the properties that hold locally in time:
- the pins are never high together;
- the unselected pin is low;
- both pins drop one clock after the enable falls;
- a zero word gives no pulse;
- a full coarse field keeps the output high until the last clock of the period;
- the period counter moves only when the clock counter wraps.

The exact placement of each high clock cannot be checked from a single cycle. This covers the coarse high time, which periods the bit-reversed index extends, and the total number of high clocks in a frame. The bench's scenarios show these by comparing whole frames against a model of the requirements. Only those scenarios also show that a word written in mid-frame is deferred to the next frame boundary.

// File: rtl/vsyn_pkg.sv
package vsyn_pkg;
  // Strobes from the sequencing logic to the pulse datapath.
  typedef struct packed {
    logic run;      // generator active this cycle
    logic loadVal;  // move the pending word into the applied word
  } vsynStrobe_t;
endpackage

// File: rtl/vsyn_ctrl.sv
module vsyn_ctrl
  import vsyn_pkg::*;
#(
  parameter int PWM_BITS = 8,
  parameter int BRM_BITS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  output logic [PWM_BITS-1:0] phase,
  output logic [BRM_BITS-1:0] period,
  output vsynStrobe_t         strobe
);
  localparam logic [PWM_BITS-1:0] PH_MAX  = {PWM_BITS{1'b1}};
  localparam logic [BRM_BITS-1:0] PER_MAX = {BRM_BITS{1'b1}};

  logic phaseWrap;
  logic frameEnd;

  assign phaseWrap = (phase == PH_MAX);
  assign frameEnd  = phaseWrap && (period == PER_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      period <= '0;
    end else if (!enable) begin
      phase  <= '0;
      period <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phaseWrap) period <= period + 1'b1;
    end
  end

  always_comb begin
    strobe.run     = enable;
    strobe.loadVal = !enable || frameEnd;
  end
endmodule

// File: rtl/vsyn_dp.sv
module vsyn_dp
  import vsyn_pkg::*;
#(
  parameter int PWM_BITS = 8,
  parameter int BRM_BITS = 6,
  localparam int CTRL_W  = PWM_BITS + BRM_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [CTRL_W-1:0]   wrData,
  input  logic                outSel,
  input  vsynStrobe_t         strobe,
  input  logic [PWM_BITS-1:0] phase,
  input  logic [BRM_BITS-1:0] period,
  output logic [CTRL_W-1:0]   actVal,
  output logic                vsOut0,
  output logic                vsOut1
);
  logic [CTRL_W-1:0]   pendVal;
  logic [PWM_BITS-1:0] coarse;
  logic [BRM_BITS-1:0] fine;
  logic [BRM_BITS-1:0] bitRev;
  logic                extend;
  logic [PWM_BITS:0]   highLen;
  logic                pulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVal <= '0;
      actVal  <= '0;
    end else begin
      if (wrEn) pendVal <= wrData;
      if (strobe.loadVal) actVal <= pendVal;
    end
  end

  assign coarse = actVal[CTRL_W-1:BRM_BITS];
  assign fine   = actVal[BRM_BITS-1:0];

  // Reverse the period index so extended periods spread evenly.
  for (genvar i = 0; i < BRM_BITS; i++) begin : g_rev
    assign bitRev[i] = period[BRM_BITS-1-i];
  end

  assign extend  = (bitRev < fine);
  assign highLen = {1'b0, coarse} + {{PWM_BITS{1'b0}}, extend};
  assign pulse   = strobe.run && ({1'b0, phase} < highLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsOut0 <= 1'b0;
      vsOut1 <= 1'b0;
    end else begin
      vsOut0 <= pulse && !outSel;
      vsOut1 <= pulse && outSel;
    end
  end
endmodule

// File: rtl/vsyn_top.sv
module vsyn_top
  import vsyn_pkg::*;
#(
  parameter int PWM_BITS = 8,
  parameter int BRM_BITS = 6,
  localparam int CTRL_W  = PWM_BITS + BRM_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              enable,
  input  logic              outSel,
  output logic              vsOut0,
  output logic              vsOut1
);
  logic [PWM_BITS-1:0] phase;
  logic [BRM_BITS-1:0] period;
  logic [CTRL_W-1:0]   actVal;
  vsynStrobe_t         strobe;

  vsyn_ctrl #(.PWM_BITS(PWM_BITS), .BRM_BITS(BRM_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .phase(phase), .period(period), .strobe(strobe)
  );

  vsyn_dp #(.PWM_BITS(PWM_BITS), .BRM_BITS(BRM_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .outSel(outSel),
    .strobe(strobe), .phase(phase), .period(period), .actVal(actVal),
    .vsOut0(vsOut0), .vsOut1(vsOut1)
  );
endmodule

// File: rtl/vsyn_chk.sv
module vsyn_chk #(
  parameter int PWM_BITS = 8,
  parameter int BRM_BITS = 6,
  localparam int CTRL_W  = PWM_BITS + BRM_BITS
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic                outSel,
  input logic                vsOut0,
  input logic                vsOut1,
  input logic [CTRL_W-1:0]   actVal,
  input logic [PWM_BITS-1:0] phase,
  input logic [BRM_BITS-1:0] period
);
  localparam logic [PWM_BITS-1:0] PH_MAX = {PWM_BITS{1'b1}};

  always_comb begin
    if (rstN) begin
      p_pins_exclusive_r7: assert ($onehot0({vsOut0, vsOut1}))
        else $error("both output pins high");
    end
  end

  p_unsel0_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    outSel |=> !vsOut0) else $error("pin 0 high while pin 1 selected");

  p_unsel1_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outSel |=> !vsOut1) else $error("pin 1 high while pin 0 selected");

  p_disable_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!vsOut0 && !vsOut1)) else $error("output while disabled");

  p_zero_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (actVal == '0) |=> (!vsOut0 && !vsOut1)) else $error("pulse from zero word");

  p_full_coarse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (actVal[CTRL_W-1 -: PWM_BITS] == PH_MAX) && (phase != PH_MAX))
      |=> (vsOut0 || vsOut1)) else $error("full coarse word dropped low early");

  p_period_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (phase != PH_MAX)) |=> (period == $past(period)))
    else $error("period advanced without phase wrap");
endmodule

bind vsyn_top vsyn_chk #(.PWM_BITS(PWM_BITS), .BRM_BITS(BRM_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .outSel(outSel),
  .vsOut0(vsOut0), .vsOut1(vsOut1), .actVal(actVal),
  .phase(phase), .period(period)
);

// File: tb/vsyn_top_bench.sv
module vsyn_top_bench;
  localparam int FRAME = 16384;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [13:0] wrData = '0;
  logic        enable = 1'b0;
  logic        outSel = 1'b0;
  logic        vsOut0, vsOut1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vsyn_top u_vsyn_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .enable(enable), .outSel(outSel), .vsOut0(vsOut0), .vsOut1(vsOut1)
  );

  function automatic logic expOut(int val, int j);
    int coarse = val >> 6;
    int fine   = val & 63;
    int ph     = j % 256;
    int per    = (j / 256) % 64;
    int rev    = 0;
    for (int b = 0; b < 6; b++) if (per[b]) rev |= (1 << (5 - b));
    return ph < (coarse + ((rev < fine) ? 1 : 0));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Disable, load a word, then enable with the given pin selected.
  task automatic startWith(int val, logic sel);
    @(negedge clk);
    enable = 1'b0; wrEn = 1'b1; wrData = 14'(val);
    @(negedge clk);
    wrEn = 1'b0;
    repeat (3) @(negedge clk);
    outSel = sel; enable = 1'b1;
  endtask

  // Compare n cycles against the model; optionally write valB at cycle wAt.
  task automatic runSpan(string req, int valA, int valB, int wAt, int n, logic sel);
    int bad = 0, highs = 0, firstJ = -1, firstAct = 0, firstExp = 0, other = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      begin
        logic e = expOut((j < FRAME) ? valA : valB, j);
        logic a = sel ? vsOut1 : vsOut0;
        logic o = sel ? vsOut0 : vsOut1;
        if (a) highs++;
        if (o) other++;
        if (a != e) begin
          bad++;
          if (firstJ < 0) begin firstJ = j; firstAct = a; firstExp = e; end
        end
      end
      if (j == wAt) begin wrEn = 1'b1; wrData = 14'(valB); end
      else wrEn = 1'b0;
    end
    check(req, "mismatching cycles", bad, 0);
    if (firstJ >= 0)
      $display("FAIL %s first mismatch at cycle %0d: actual=%0d expected=%0d",
               req, firstJ, firstAct, firstExp);
    check("R7", "unselected pin high cycles", other, 0);
    if (n == FRAME)
      check(req, "high clocks in frame", highs, 64 * (valA >> 6) + (valA & 63));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "vsOut0 in reset", vsOut0, 0);
    check("R1", "vsOut1 in reset", vsOut1, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "vsOut0 after reset", vsOut0, 0);
    check("R1", "vsOut1 after reset", vsOut1, 0);
  endtask

  task automatic testZero();
    startWith(0, 1'b0);
    runSpan("R4", 0, 0, -1, 1024, 1'b0);
  endtask

  task automatic testMid();
    startWith((100 << 6) | 21, 1'b0);
    runSpan("R2", (100 << 6) | 21, 0, -1, FRAME, 1'b0);
  endtask

  task automatic testMax();
    startWith(16383, 1'b0);
    runSpan("R5", 16383, 0, -1, FRAME, 1'b0);
  endtask

  task automatic testSpread();
    startWith(1, 1'b0);
    runSpan("R3", 1, 0, -1, FRAME, 1'b0);
    startWith((3 << 6) | 32, 1'b0);
    runSpan("R3", (3 << 6) | 32, 0, -1, 4096, 1'b0);
  endtask

  task automatic testSelect();
    startWith((200 << 6) | 45, 1'b1);
    runSpan("R7", (200 << 6) | 45, 0, -1, 2048, 1'b1);
  endtask

  task automatic testDeferred();
    startWith((40 << 6) | 7, 1'b0);
    runSpan("R6", (40 << 6) | 7, (180 << 6) | 50, 2600, 2 * FRAME, 1'b0);
  endtask

  task automatic testDisable();
    int highs = 0;
    startWith(16383, 1'b0);
    repeat (300) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R8", "vsOut0 one cycle after disable", vsOut0, 0);
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (vsOut0 || vsOut1) highs++;
    end
    check("R8", "high cycles while disabled", highs, 0);
    outSel = 1'b0; enable = 1'b1;
    runSpan("R8", 16383, 0, -1, 600, 1'b0);
  endtask

  initial begin
    testReset();
    testZero();
    testMid();
    testMax();
    testSpread();
    testSelect();
    testDeferred();
    testDisable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule